// File: doc/BRIEF.md
# Console Bus Address Decoder

This block sits on the 24-bit address bus of a small 32-bit console and turns each access into one chip select. It serves four targets: two peripheral timer/IO chips (A and B), the custom-chip register file and a companion-chip register file. It also gives the target a short register offset with the mirroring already folded away. Accesses that hit no target are answered with zero read data, so software never sees a floating bus.

The chip selects and the offset are combinational from the address and the two strobes. Read data from the addressed target is captured into an output register on each clock edge where the read strobe is high. All windows, spans, the field that picks peripheral A or B, and the mapping of that field are parameters.

The peripheral select takes address bits [13:12]. Values 0 and 1 pick A; values 2 and 3 pick B. With the default peripheral window both reachable values of that field pick B. A wider window at the same top reaches chip A.

Top module: `bus_addr_decode`

## Requirements
- R1: A read whose address hits no target window makes `bus_rdata` equal zero after the next rising clock edge.
- R2: Addresses 0xBFE000 through 0xBFFFFF, and no others, assert a peripheral select (`peri_a_cs` or `peri_b_cs`) during an access.
- R3: Inside the peripheral window, address bits [13:12] equal to 0 or 1 assert `peri_a_cs`, and equal to 2 or 3 assert `peri_b_cs`.
- R4: Addresses 0xC00000 through 0xCFFFFF assert `custom_cs` during an access.
- R5: Addresses 0xB90000 through 0xB9FFFF also assert `custom_cs` during an access. They present the same offsets as the main custom window.
- R6: Addresses 0xB80000 through 0xB87FFF assert `comp_cs`. Addresses 0xB88000 through 0xB8FFFF are unmapped.
- R7: `reg_offset` (9 bits) carries address bits [5:0] zero-extended while `comp_cs` is high, so the companion registers repeat every 64 bytes. It carries address bits [8:0] while `custom_cs` is high, and it is zero otherwise.
- R8: At most one chip select is high at any time. None is high unless `bus_rd` or `bus_wr` is high.
- R9: On a rising edge with `bus_rd` high, `bus_rdata` loads the read data of the selected target. On an edge with `bus_rd` low, including a write-only access, it keeps its value.
- R10: While `rst_n` is low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 24 | Byte address of the current access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| peri_a_rdata | input | 32 | Read data from peripheral chip A |
| peri_b_rdata | input | 32 | Read data from peripheral chip B |
| custom_rdata | input | 32 | Read data from the custom-chip registers |
| comp_rdata | input | 32 | Read data from the companion-chip registers |
| peri_a_cs | output | 1 | Select for peripheral chip A |
| peri_b_cs | output | 1 | Select for peripheral chip B |
| custom_cs | output | 1 | Select for the custom-chip registers |
| comp_cs | output | 1 | Select for the companion-chip registers |
| reg_offset | output | 9 | Mirrored register offset for the selected target |
| bus_rdata | output | 32 | Registered read data, zero for unmapped reads |

## Verification
The bench drives addresses one byte either side of every window edge and sweeps in fine steps across the whole region from 0xB7F000 to 0xC01000. A decoder whose spans were off by one would select a neighbour or leave a gap, and one that decoded the companion window across all of 0xB8xxxx would claim the unmapped upper half. Offset sweeps over each custom window and across several 64-byte repeats of the companion window show whether bits leak past the mirror width. A second instance with a 16 KB peripheral window reaches every value of bits [13:12]; an inverted or one-hot mapping would show up there as the wrong chip. Read data is stamped with the address, so a mux that returns stale data, forwards the bus on an unmapped read, or updates on a write is caught.

// File: rtl/busdec_pkg.sv
package busdec_pkg;

   typedef enum logic [2:0] {
      TGT_NONE   = 3'd0,
      TGT_PERI_A = 3'd1,
      TGT_PERI_B = 3'd2,
      TGT_CUSTOM = 3'd3,
      TGT_COMP   = 3'd4
   } tgt_e;

   localparam int MAP_PAIRED = 0;
   localparam int MAP_SPLIT  = 1;

   localparam int WIN_PERI  = 0;
   localparam int WIN_CUST  = 1;
   localparam int WIN_CUSTM = 2;
   localparam int WIN_COMP  = 3;
   localparam int NUM_WIN   = 4;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/busdec_window.sv
module busdec_window #(
   parameter int          AW        = 24,
   parameter int unsigned BASE      = 0,
   parameter int          SPAN_LOG2 = 12
) (
   input  logic [AW-1:0] addr,
   output logic          hit
);
   localparam logic [AW-1:0] BASE_V   = AW'(BASE);
   localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << SPAN_LOG2) - 64'd1);
   localparam logic [AW-1:0] TAG_V    = BASE_V >> SPAN_LOG2;

   if (SPAN_LOG2 < 1 || SPAN_LOG2 >= AW) begin : g_bad_span
      $error("busdec_window: SPAN_LOG2 must lie in 1..AW-1");
   end
   if ((BASE_V & LOW_MASK) != '0) begin : g_bad_align
      $error("busdec_window: BASE is not aligned to its span");
   end

   assign hit = ((addr >> SPAN_LOG2) == TAG_V);

endmodule

// File: rtl/busdec_peri_sel.sv
module busdec_peri_sel #(
   parameter int MAP = 0
) (
   input  logic [1:0] code,
   output logic       sel_a,
   output logic       sel_b
);
   import busdec_pkg::*;

   if (MAP == MAP_PAIRED) begin : g_paired
      assign sel_a = ~code[1];
      assign sel_b =  code[1];
   end else if (MAP == MAP_SPLIT) begin : g_split
      assign sel_a = (code == 2'd1);
      assign sel_b = (code == 2'd2);
   end else begin : g_bad_map
      $error("busdec_peri_sel: unknown MAP value");
      assign sel_a = 1'b0;
      assign sel_b = 1'b0;
   end

endmodule

// File: rtl/busdec_rdmux.sv
module busdec_rdmux #(
   parameter int DW = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd,
   input  busdec_pkg::tgt_e tgt,
   input  logic [DW-1:0]    d_peri_a,
   input  logic [DW-1:0]    d_peri_b,
   input  logic [DW-1:0]    d_custom,
   input  logic [DW-1:0]    d_comp,
   output logic [DW-1:0]    rdata
);
   import busdec_pkg::*;

   logic [DW-1:0] sel_data;

   always_comb begin
      unique case (tgt)
         TGT_PERI_A: sel_data = d_peri_a;
         TGT_PERI_B: sel_data = d_peri_b;
         TGT_CUSTOM: sel_data = d_custom;
         TGT_COMP:   sel_data = d_comp;
         default:    sel_data = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         rdata <= sel_data;
      end
   end

endmodule

// File: rtl/bus_addr_decode.sv
module bus_addr_decode #(
   parameter int          ADDR_W          = 24,
   parameter int          DATA_W          = 32,
   parameter int unsigned PERI_BASE       = 'hBFE000,
   parameter int          PERI_SPAN_LOG2  = 13,
   parameter int          PERI_SEL_LSB    = 12,
   parameter int          PERI_MAP        = 0,
   parameter int unsigned CUST_BASE       = 'hC00000,
   parameter int          CUST_SPAN_LOG2  = 20,
   parameter int unsigned CUSTM_BASE      = 'hB90000,
   parameter int          CUSTM_SPAN_LOG2 = 16,
   parameter int unsigned COMP_BASE       = 'hB80000,
   parameter int          COMP_SPAN_LOG2  = 15,
   parameter int          CUST_OFS_W      = 9,
   parameter int          COMP_OFS_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [23:0]       bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [31:0]       peri_a_rdata,
   input  logic [31:0]       peri_b_rdata,
   input  logic [31:0]       custom_rdata,
   input  logic [31:0]       comp_rdata,
   output logic              peri_a_cs,
   output logic              peri_b_cs,
   output logic              custom_cs,
   output logic              comp_cs,
   output logic [8:0]        reg_offset,
   output logic [31:0]       bus_rdata
);
   import busdec_pkg::*;

   localparam int OFS_W = imax(CUST_OFS_W, COMP_OFS_W);
   localparam int unsigned WBASE [NUM_WIN] = '{PERI_BASE, CUST_BASE, CUSTM_BASE, COMP_BASE};
   localparam int          WSPAN [NUM_WIN] = '{PERI_SPAN_LOG2, CUST_SPAN_LOG2,
                                               CUSTM_SPAN_LOG2, COMP_SPAN_LOG2};

   // ---------------- elaboration checks ----------------
   if (ADDR_W != 24 || DATA_W != 32) begin : g_bad_width
      $error("bus_addr_decode: port widths are fixed at 24 address and 32 data bits");
   end
   if (OFS_W != 9) begin : g_bad_ofs
      $error("bus_addr_decode: reg_offset is 9 bits wide");
   end
   if (PERI_SEL_LSB + 1 >= ADDR_W) begin : g_bad_sel
      $error("bus_addr_decode: peripheral select field out of range");
   end
   if (CUST_OFS_W > CUST_SPAN_LOG2 || CUST_OFS_W > CUSTM_SPAN_LOG2) begin : g_bad_cofs
      $error("bus_addr_decode: custom offset wider than its windows");
   end
   if (COMP_OFS_W > COMP_SPAN_LOG2) begin : g_bad_mofs
      $error("bus_addr_decode: companion offset wider than its window");
   end
   for (genvar i = 0; i < NUM_WIN; i++) begin : g_ovl_i
      for (genvar j = i + 1; j < NUM_WIN; j++) begin : g_ovl_j
         localparam int SP = imax(WSPAN[i], WSPAN[j]);
         if ((WBASE[i] >> SP) == (WBASE[j] >> SP)) begin : g_overlap
            $error("bus_addr_decode: two target windows overlap");
         end
      end
   end

   // ---------------- window match ----------------
   logic [NUM_WIN-1:0] win_hit;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      busdec_window #(
         .AW        (ADDR_W),
         .BASE      (WBASE[g]),
         .SPAN_LOG2 (WSPAN[g])
      ) u_win (
         .addr (bus_addr),
         .hit  (win_hit[g])
      );
   end

   // ---------------- peripheral chip choice ----------------
   logic peri_pick_a;
   logic peri_pick_b;

   busdec_peri_sel #(
      .MAP (PERI_MAP)
   ) u_peri_sel (
      .code  (bus_addr[PERI_SEL_LSB+1:PERI_SEL_LSB]),
      .sel_a (peri_pick_a),
      .sel_b (peri_pick_b)
   );

   // ---------------- select generation ----------------
   logic access;
   logic hit_peri;
   logic hit_cust;
   logic hit_comp;

   assign access   = bus_rd | bus_wr;
   assign hit_peri = win_hit[WIN_PERI];
   assign hit_cust = ~hit_peri & (win_hit[WIN_CUST] | win_hit[WIN_CUSTM]);
   assign hit_comp = ~hit_peri & ~hit_cust & win_hit[WIN_COMP];

   assign peri_a_cs = access & hit_peri & peri_pick_a;
   assign peri_b_cs = access & hit_peri & peri_pick_b;
   assign custom_cs = access & hit_cust;
   assign comp_cs   = access & hit_comp;

   // ---------------- mirrored register offset ----------------
   always_comb begin
      if (custom_cs) begin
         reg_offset = OFS_W'(bus_addr[CUST_OFS_W-1:0]);
      end else if (comp_cs) begin
         reg_offset = OFS_W'(bus_addr[COMP_OFS_W-1:0]);
      end else begin
         reg_offset = '0;
      end
   end

   // ---------------- read data ----------------
   tgt_e tgt;

   always_comb begin
      if (peri_a_cs)      tgt = TGT_PERI_A;
      else if (peri_b_cs) tgt = TGT_PERI_B;
      else if (custom_cs) tgt = TGT_CUSTOM;
      else if (comp_cs)   tgt = TGT_COMP;
      else                tgt = TGT_NONE;
   end

   busdec_rdmux #(
      .DW (DATA_W)
   ) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (bus_rd),
      .tgt      (tgt),
      .d_peri_a (peri_a_rdata),
      .d_peri_b (peri_b_rdata),
      .d_custom (custom_rdata),
      .d_comp   (comp_rdata),
      .rdata    (bus_rdata)
   );

endmodule

// File: rtl/busdec_chk.sv
module busdec_chk #(
   parameter int AW         = 24,
   parameter int DW         = 32,
   parameter int SEL_LSB    = 12,
   parameter int MAP        = 0,
   parameter int COMP_OFS_W = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] bus_addr,
   input logic          bus_rd,
   input logic          bus_wr,
   input logic [DW-1:0] custom_rdata,
   input logic [DW-1:0] comp_rdata,
   input logic          peri_a_cs,
   input logic          peri_b_cs,
   input logic          custom_cs,
   input logic          comp_cs,
   input logic [8:0]    reg_offset,
   input logic [DW-1:0] bus_rdata
);
   logic any_cs;
   assign any_cs = peri_a_cs | peri_b_cs | custom_cs | comp_cs;

   // R8
   a_r8_onehot_cs: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({peri_a_cs, peri_b_cs, custom_cs, comp_cs}));

   // R8
   a_r8_no_strobe_no_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd | bus_wr) |-> !any_cs);

   // R1
   a_r1_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !any_cs) |=> (bus_rdata == '0));

   // R9
   a_r9_capture_custom: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && custom_cs) |=> (bus_rdata == $past(custom_rdata)));

   // R9
   a_r9_capture_comp: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && comp_cs) |=> (bus_rdata == $past(comp_rdata)));

   // R9
   a_r9_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));

   // R7
   a_r7_comp_offset_narrow: assert property (@(posedge clk) disable iff (!rst_n)
      comp_cs |-> ((reg_offset >> COMP_OFS_W) == '0));

   // R7
   a_r7_idle_offset_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(custom_cs | comp_cs) |-> (reg_offset == '0));

   // R3
   if (MAP == 0) begin : g_paired_chk
      a_r3_a_low_half: assert property (@(posedge clk) disable iff (!rst_n)
         peri_a_cs |-> !bus_addr[SEL_LSB+1]);
      a_r3_b_high_half: assert property (@(posedge clk) disable iff (!rst_n)
         peri_b_cs |-> bus_addr[SEL_LSB+1]);
   end

endmodule

bind bus_addr_decode busdec_chk #(
   .AW         (ADDR_W),
   .DW         (DATA_W),
   .SEL_LSB    (PERI_SEL_LSB),
   .MAP        (PERI_MAP),
   .COMP_OFS_W (COMP_OFS_W)
) u_busdec_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_addr     (bus_addr),
   .bus_rd       (bus_rd),
   .bus_wr       (bus_wr),
   .custom_rdata (custom_rdata),
   .comp_rdata   (comp_rdata),
   .peri_a_cs    (peri_a_cs),
   .peri_b_cs    (peri_b_cs),
   .custom_cs    (custom_cs),
   .comp_cs      (comp_cs),
   .reg_offset   (reg_offset),
   .bus_rdata    (bus_rdata)
);

// File: tb/tb_bus_addr_decode.sv
`timescale 1ns/1ps
module tb_bus_addr_decode;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] addr = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [31:0] d_a, d_b, d_cu, d_co;

   logic        a_cs, b_cs, cu_cs, co_cs;
   logic [8:0]  ofs;
   logic [31:0] rdata;
   logic        wa_cs, wb_cs, wcu_cs, wco_cs;
   logic [8:0]  wofs;
   logic [31:0] wrdata;

   int checks = 0;
   int fails  = 0;
   logic [31:0] prev_rdata = '0;

   always #2 clk = ~clk;

   assign d_a  = {8'hA1, addr};
   assign d_b  = {8'hB2, addr};
   assign d_cu = {8'hC3, addr};
   assign d_co = {8'hD4, addr};

   bus_addr_decode dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
      .peri_a_rdata(d_a), .peri_b_rdata(d_b), .custom_rdata(d_cu), .comp_rdata(d_co),
      .peri_a_cs(a_cs), .peri_b_cs(b_cs), .custom_cs(cu_cs), .comp_cs(co_cs),
      .reg_offset(ofs), .bus_rdata(rdata));

   bus_addr_decode #(.PERI_BASE('hBFC000), .PERI_SPAN_LOG2(14)) dut_wide (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
      .peri_a_rdata(d_a), .peri_b_rdata(d_b), .custom_rdata(d_cu), .comp_rdata(d_co),
      .peri_a_cs(wa_cs), .peri_b_cs(wb_cs), .custom_cs(wcu_cs), .comp_cs(wco_cs),
      .reg_offset(wofs), .bus_rdata(wrdata));

   // 0 none, 1 chip A, 2 chip B, 3 custom, 4 companion
   function automatic int model_tgt(input logic [23:0] a, input int unsigned plo);
      int unsigned v = int'(a);
      if (v >= plo && v <= 'hBFFFFF) return (((v >> 12) & 3) < 2) ? 1 : 2;
      if (v >= 'hC00000 && v <= 'hCFFFFF) return 3;
      if (v >= 'hB90000 && v <= 'hB9FFFF) return 3;
      if (v >= 'hB80000 && v <= 'hB87FFF) return 4;
      return 0;
   endfunction

   function automatic string req_of(input logic [23:0] a, input int t);
      if (t == 1 || t == 2) return "R2 R3";
      if (t == 3) return (a[23:16] == 8'hB9) ? "R5" : "R4";
      if (t == 4) return "R6";
      return "R2 R6";
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s addr=%06h actual=%08h expected=%08h", req, what, addr, act, exp);
      end
   endtask

   task automatic access(input logic [23:0] a, input bit r, input bit w);
      int t, tw;
      logic [3:0]  exp_cs, exp_wcs;
      logic [8:0]  exp_ofs;
      logic [31:0] exp_rd;
      @(negedge clk);
      addr = a; rd = r; wr = w;
      #1;
      t  = model_tgt(a, 'hBFE000);
      tw = model_tgt(a, 'hBFC000);
      exp_cs  = (r | w) ? 4'((t  == 0) ? 0 : (1 << (t  - 1))) : 4'd0;
      exp_wcs = (r | w) ? 4'((tw == 0) ? 0 : (1 << (tw - 1))) : 4'd0;
      if (!(r | w))            exp_ofs = '0;
      else if (t == 3)         exp_ofs = a[8:0];
      else if (t == 4)         exp_ofs = {3'b000, a[5:0]};
      else                     exp_ofs = '0;
      check({co_cs, cu_cs, b_cs, a_cs} == exp_cs,
            (r | w) ? {req_of(a, t), " R8"} : "R8", "selects",
            32'({co_cs, cu_cs, b_cs, a_cs}), 32'(exp_cs));
      check({wco_cs, wcu_cs, wb_cs, wa_cs} == exp_wcs, "R3 wide", "selects",
            32'({wco_cs, wcu_cs, wb_cs, wa_cs}), 32'(exp_wcs));
      check(ofs == exp_ofs, "R7", "offset", 32'(ofs), 32'(exp_ofs));
      case (t)
         1: exp_rd = d_a;
         2: exp_rd = d_b;
         3: exp_rd = d_cu;
         4: exp_rd = d_co;
         default: exp_rd = '0;
      endcase
      if (!r) exp_rd = prev_rdata;
      @(posedge clk);
      #1;
      check(rdata == exp_rd, (!r) ? "R9" : ((t == 0) ? "R1" : "R9"), "rdata", rdata, exp_rd);
      prev_rdata = rdata;
   endtask

   initial begin
      #(4 * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      addr = 24'hC00010; rd = 1'b1;
      @(posedge clk); #1;
      check(rdata == '0, "R10", "reset rdata", rdata, '0);
      check(wrdata == '0, "R10", "reset rdata wide", wrdata, '0);
      @(negedge clk);
      rd = 1'b0;
      rst_n = 1'b1;

      // coarse sweep over the full space, 64 KB steps
      for (int k = 0; k < 256; k++) access(24'(k << 16), 1'b1, 1'b0);

      // fine sweep across the busy region
      for (int a = 'hB7F000; a <= 'hC01000; a += 'h100) access(24'(a), 1'b1, 1'b0);

      // window edges, one byte either side
      access(24'hB7FFFF, 1, 0); access(24'hB80000, 1, 0);
      access(24'hB87FFF, 1, 0); access(24'hB88000, 1, 0);
      access(24'hB8FFFF, 1, 0); access(24'hB90000, 1, 0);
      access(24'hB9FFFF, 1, 0); access(24'hBA0000, 1, 0);
      access(24'hBFDFFF, 1, 0); access(24'hBFE000, 1, 0);
      access(24'hBFEFFF, 1, 0); access(24'hBFF000, 1, 0);
      access(24'hBFFFFF, 1, 0); access(24'hC00000, 1, 0);
      access(24'hCFFFFF, 1, 0); access(24'hD00000, 1, 0);
      access(24'hBFBFFF, 1, 0); access(24'hBFC000, 1, 0);
      access(24'hBFD000, 1, 0);
      access(24'h000000, 1, 0); access(24'hFFFFFF, 1, 0);

      // companion mirror (R6, R7): several 64-byte repeats
      for (int i = 0; i < 200; i++) access(24'('hB80000 + i), 1'b1, 1'b0);
      for (int i = 0; i < 80; i++)  access(24'('hB87F80 + i), 1'b1, 1'b0);

      // custom offsets in both windows (R4, R5, R7)
      for (int i = 0; i < 1100; i++) access(24'('hC00000 + i), 1'b1, 1'b0);
      for (int i = 0; i < 600; i++)  access(24'('hB9FD00 + i), 1'b1, 1'b0);
      for (int i = 0; i < 300; i++)  access(24'('hCFFE00 + i), 1'b1, 1'b0);

      // peripheral field sweep, both instances (R3)
      for (int i = 0; i < 64; i++) access(24'('hBFC000 + i * 'h100), 1'b1, 1'b0);

      // writes do not disturb read data; idle asserts nothing (R8, R9)
      access(24'hC00123, 1, 0);
      access(24'hB80011, 0, 1);
      access(24'hBFF004, 0, 1);
      access(24'hB88000, 0, 1);
      access(24'hB90042, 0, 0);
      access(24'hBFE000, 0, 0);
      access(24'hB88000, 1, 0);
      access(24'hC00040, 1, 1);
      access(24'hB9000A, 0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule